// File: doc/BRIEF.md
# Down-Counting Capture Timer

This block measures time intervals by counting down from all ones and latching the live count when an external event arrives. Counting is gated by a software enable and advances only on cycles where a count-clock enable strobe is high. A prescaler supplies that strobe from outside the block. The capture pin is asynchronous. It is brought into the clock domain through a two-flop synchronizer, and a rising edge of the synchronized level counts as one capture event.

A single control word is written through a one-cycle write strobe. It holds the run bit, the mode bit and two interrupt enables. In clear mode each capture restarts the count from all ones, so the measure register holds the time since the previous event. In free-run mode captures leave the counter alone, so the counter wraps on underflow and acts as a timestamp base. Capture and underflow each raise a one-cycle interrupt pulse. The live count and the measure register are both visible at the outputs.

Top module: `cap_timer`

## Requirements
- R1: After reset, `count_o`, `meas_o`, `irq_cap_o` and `irq_unf_o` are all zero.
- R2: Control word fields are bit 0 run, bit 1 mode (0 = clear, 1 = free-run), bit 2 capture interrupt enable and bit 3 underflow interrupt enable. A write that sets run while the block is stopped loads `count_o` with 16'hFFFF at that clock edge. While running, the count drops by one on each edge where `tick_i` is high, and it holds while `tick_i` is low.
- R3: A write that clears run freezes `count_o` at its current value.
- R4: A rising edge on `cap_i` is recognised at the third clock edge after it. At that edge `meas_o` takes the count present just before that edge.
- R5: In clear mode a capture sets the counter to 16'hFFFF, whatever the state of `tick_i`.
- R6: In free-run mode a capture does not change the count sequence. In either mode, a tick at count zero wraps the counter to 16'hFFFF.
- R7: Each underflow raises `irq_unf_o` for exactly one cycle when bit 3 is set. The pulse appears in the same cycle that `count_o` shows 16'hFFFF.
- R8: Each capture raises `irq_cap_o` for exactly one cycle, in the same cycle `meas_o` updates, when bit 2 is set. With bit 2 clear, `meas_o` still updates and `irq_cap_o` stays low.
- R9: When a capture and an underflow fall on the same edge, `meas_o` takes zero, the count wraps to 16'hFFFF, and both interrupt pulses assert.
- R10: While run is clear, capture edges change neither `meas_o` nor `irq_cap_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable strobe |
| cap_i | input | 1 | Asynchronous capture pin |
| wr_i | input | 1 | Control word write strobe |
| wr_data_i | input | 4 | Control word |
| count_o | output | 16 | Live counter value |
| meas_o | output | 16 | Measure register |
| irq_cap_o | output | 1 | Capture interrupt pulse |
| irq_unf_o | output | 1 | Underflow interrupt pulse |

## Verification
The counter assertions assume that run is only ever started from the stopped state through a write. They also assume that `tick_i` is a plain level, sampled once per clock edge. The bench drives every input on the falling edge, and it holds `cap_i` steady for at least three cycles per level, so the synchronizer sees clean levels. The coincidence case is lined up by counting ticks from the start write. This places the third synchronizer edge exactly on the cycle where the count reads zero.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int unsigned CTRL_W = 4;

  typedef struct packed {
    logic ie_unf;
    logic ie_cap;
    logic free_run;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= sh_q[g-1];
    end
  end

  // last stage only holds the previous synchronized level
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r4_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             reload_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             unf_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [WIDTH-1:0] cnt_q;

  assign unf_o = run_i & tick_i & ~start_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= ALL_ONES;
    else if (run_i && reload_i) cnt_q <= ALL_ONES;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == '0) ? ALL_ONES : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !reload_i && !(run_i && tick_i)) |=> $stable(cnt_q));
  a_r2_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !start_i && !reload_i && cnt_q != '0)
      |=> cnt_q == WIDTH'($past(cnt_q) - 1'b1));
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> cnt_q == ALL_ONES);
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && reload_i) |=> cnt_q == ALL_ONES);
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cap_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  meas_o,
  output logic              irq_cap_o,
  output logic              irq_unf_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  ctrl_t            ctrl_q, wr_ctrl;
  logic             cap_rise, cap_fire, start, unf;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] meas_q;
  logic             irq_cap_q, irq_unf_q;

  assign wr_ctrl = ctrl_t'(wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wr_ctrl;

  // only a stopped-to-running write reinitialises the count
  assign start    = wr_i & wr_ctrl.run & ~ctrl_q.run;
  assign cap_fire = cap_rise & ctrl_q.run;

  cap_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cap_i),
    .rise_o  (cap_rise)
  );

  down_counter #(.WIDTH(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.run),
    .tick_i   (tick_i),
    .start_i  (start),
    .reload_i (cap_fire & ~ctrl_q.free_run),
    .cnt_o    (cnt),
    .unf_o    (unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_q    <= '0;
      irq_cap_q <= 1'b0;
      irq_unf_q <= 1'b0;
    end else begin
      if (cap_fire) meas_q <= cnt;
      irq_cap_q <= cap_fire & ctrl_q.ie_cap;
      irq_unf_q <= unf & ctrl_q.ie_unf;
    end
  end

  assign count_o   = cnt;
  assign meas_o    = meas_q;
  assign irq_cap_o = irq_cap_q;
  assign irq_unf_o = irq_unf_q;

  a_r8_cap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cap_o |=> !irq_cap_o);
  a_r7_unf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_unf_o |=> !irq_unf_o);
  a_r7_unf_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_unf_o |-> count_o == ALL_ONES);
  a_r10_idle_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run |=> ($stable(meas_o) && !irq_cap_o));
endmodule

// File: tb/cap_timer_tb.sv
`timescale 1ns/1ps
module cap_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cap = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  wdata = '0;
  logic [15:0] count, meas;
  logic        irq_cap, irq_unf;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  cap_timer u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .cap_i     (cap),
    .wr_i      (wr),
    .wr_data_i (wdata),
    .count_o   (count),
    .meas_o    (meas),
    .irq_cap_o (irq_cap),
    .irq_unf_o (irq_unf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [3:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // raise cap now, return at the negedge after the capturing edge
  task automatic cap_rise3();
    cap = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cap_drop();
    cap = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 meas", meas, 0);
    check("R1 irqs", {irq_cap, irq_unf}, 0);
  endtask

  task automatic t_count();
    tick = 1'b1;
    write_ctrl(4'b0001);
    check("R2 start load", count, 16'hFFFF);
    repeat (5) @(negedge clk);
    check("R2 decrement", count, 16'hFFFA);
    tick = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 tick gate", count, 16'hFFFA);
    tick = 1'b1;
  endtask

  task automatic t_stop();
    logic [15:0] held;
    write_ctrl(4'b0000);
    held = count;
    repeat (5) @(negedge clk);
    check("R3 frozen", count, held);
  endtask

  task automatic t_idle_cap();
    logic [15:0] m0;
    write_ctrl(4'b0100);
    m0 = meas;
    cap_rise3();
    check("R10 meas kept", meas, m0);
    check("R10 no irq", irq_cap, 0);
    @(negedge clk);
    check("R10 no irq late", irq_cap, 0);
    cap_drop();
  endtask

  task automatic t_clear_mode();
    write_ctrl(4'b0101);
    cap_rise3();
    check("R4 meas value", meas, 16'hFFFD);
    check("R5 clear reload", count, 16'hFFFF);
    check("R8 irq_cap", irq_cap, 1);
    @(negedge clk);
    check("R8 pulse width", irq_cap, 0);
    check("R5 resumes", count, 16'hFFFE);
    cap_drop();
    write_ctrl(4'b0000);
  endtask

  task automatic t_free_mode();
    write_ctrl(4'b0111);
    cap_rise3();
    check("R4 meas free", meas, 16'hFFFD);
    check("R6 undisturbed", count, 16'hFFFC);
    check("R8 irq free", irq_cap, 1);
    cap_drop();
    write_ctrl(4'b0000);
  endtask

  task automatic t_mask();
    write_ctrl(4'b0011);
    repeat (2) @(negedge clk);
    cap_rise3();
    check("R8 masked meas", meas, 16'hFFFB);
    check("R8 masked irq", irq_cap, 0);
    @(negedge clk);
    check("R8 masked irq late", irq_cap, 0);
    cap_drop();
    write_ctrl(4'b0000);
  endtask

  task automatic t_underflow();
    write_ctrl(4'b1011);
    repeat (65535) @(negedge clk);
    check("R6 at zero", count, 0);
    check("R7 no early irq", irq_unf, 0);
    @(negedge clk);
    check("R6 wrap", count, 16'hFFFF);
    check("R7 irq_unf", irq_unf, 1);
    @(negedge clk);
    check("R7 pulse width", irq_unf, 0);
    check("R6 after wrap", count, 16'hFFFE);
    write_ctrl(4'b0000);
  endtask

  task automatic t_coincide();
    write_ctrl(4'b1111);
    repeat (65533) @(negedge clk);
    cap_rise3();
    check("R9 meas zero", meas, 0);
    check("R9 count wrap", count, 16'hFFFF);
    check("R9 both irqs", {irq_cap, irq_unf}, 2'b11);
    cap_drop();
    write_ctrl(4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_count();
    t_stop();
    t_idle_cap();
    t_clear_mode();
    t_free_mode();
    t_mask();
    t_underflow();
    t_coincide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule